// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between the register interface of a memory-card host controller and an abstract card model. A write to the 16-bit command register is decoded into a command index, a start-up flag, an expected response kind, a busy hint, a command class and a data direction. The block then raises a request to the card carrying the index and a 32-bit argument. It waits for the card to return up to sixteen response bytes together with a byte count. When they arrive, it checks that enough bytes came back for the expected kind. It then looks for error flags in the response and produces one combined update for the controller's 16-bit status word.

The status word itself lives outside the block. On every update the block provides a keep mask and a set mask, and the owner applies `new = (old & stat_and) | stat_or`. The response bytes are unpacked into eight 16-bit response registers in word-reversed order. A command of the addressed-data class produces a one-cycle pulse that resets the data FIFO and starts a transfer with a latched direction. Any other command class produces a pulse that cancels a transfer.

Top module: `cmd_resp_unit`

## Requirements
- R1: Command word fields are: index in bits 5:0, start-up flag in bit 7, response kind in bits 10:8, busy hint in bit 11, command class in bits 13:12, and direction in bit 15. After an accepted write, `req_valid` and `rsp_ready` are high from the next cycle until the cycle of the response handshake. While they are high, `req_index` and `req_arg` hold the index and the argument captured at the write.
- R2: A command write is ignored when `en` is low, and also while a request is outstanding. An ignored write issues no request, produces no status update and does not clear the response registers.
- R3: Every accepted command write clears all eight response registers in the following cycle.
- R4: An accepted write with the start-up flag set and index 0 issues no request and no transfer pulse. In the next cycle it produces a single status update with keep mask 0xFFFF and set mask 0x0001.
- R5: Response kind codes are 0 = none, 1 = short status, 2 = long 16-byte, 3 = operating conditions and 6 = published address. Code 1 with the busy hint set behaves as code 1. Codes 1, 3 and 6 need at least 4 bytes, and code 2 needs 16. A shorter count sets status bit 7 (timeout).
- R6: For code 3 with at least 4 bytes: if bit 31 of the response is set, status bits 12:0 are cleared; otherwise status bit 12 is set.
- R7: The 32-bit response value is formed from bytes 0 to 3, with byte 0 as the most significant byte. For code 1, this value is AND-ed with the short-status error mask (default 0xFDF90000). For code 6, the value of bytes 2 and 3 is AND-ed with the address error mask (default 0x0000E008). A nonzero result sets status bit 14. Otherwise status bits 14 and 11:0 are cleared.
- R8: A response is stored when the kind code is not 0 and the byte count is nonzero. Bytes 2k and 2k+1 form word k, with byte 2k in the high half. Word k goes to response register 7-k, which is `rsp_regs[16*(7-k)+15 : 16*(7-k)]`. Byte i of `rsp_bytes` is bits 8i+7:8i.
- R9: If there is no timeout, index 12 sets status bits 0 and 2, and every other index sets status bit 0.
- R10: One cycle after a non-start-up accepted write, `xfer_start` pulses if the command class is 3, with `xfer_dir` equal to bit 15 of the word. For any other class, `xfer_cancel` pulses instead.
- R11: The status update (`stat_upd` high for one cycle) and the response register load both take effect in the cycle after the `rsp_valid`/`rsp_ready` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; command writes are accepted only when high |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument, captured with the write |
| req_valid | output | 1 | Command request pending at the card |
| req_index | output | 6 | Command index of the pending request |
| req_arg | output | 32 | Argument of the pending request |
| rsp_valid | input | 1 | Card response present |
| rsp_ready | output | 1 | Block waiting for a response |
| rsp_count | input | 5 | Number of valid response bytes (0 to 16) |
| rsp_bytes | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| stat_upd | output | 1 | Apply status update this cycle |
| stat_and | output | 16 | Status keep mask |
| stat_or | output | 16 | Status set mask |
| rsp_regs | output | 128 | Eight 16-bit response registers, register j at bits 16j+15:16j |
| xfer_start | output | 1 | Pulse: reset FIFO and start a data transfer |
| xfer_cancel | output | 1 | Pulse: mark no data transfer active |
| xfer_dir | output | 1 | Direction latched at the last transfer start |

## Verification
The checker watches several behaviours on every cycle. It confirms that a pending request and its fields stay steady until the handshake, and that a disabled controller never raises a request. It checks the one-cycle timing of the status update, response clearing and transfer pulses. It also checks that each update carries exactly one of the completion and timeout bits, and that the start-up shortcut has its fixed masks. Other behaviours can only be shown by the bench's scenarios, because they depend on the response contents: the length thresholds per response kind, the error-mask selection, the handling of the operating-conditions bit, the word-reversed byte placement and the extra stop bit for index 12. The bench applies the masks to a shadow status word and compares it with a behavioural model.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;

  localparam int unsigned CMD_W  = 16;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned ARG_W  = 32;

  // Expected response kind after decode; the busy variant is kept distinct
  typedef enum logic [2:0] {
    RK_NONE,
    RK_R1,
    RK_R1B,
    RK_R2,
    RK_R3,
    RK_R6,
    RK_RAW
  } rkind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             init;
    rkind_e           kind;
    logic [1:0]       ctype;
    logic             dir;
  } cmd_fields_t;

  localparam logic [1:0]       CT_DATA  = 2'd3;
  localparam logic [IDX_W-1:0] IDX_STOP = 6'd12;

  // status bit positions
  localparam int unsigned SB_DONE = 0;
  localparam int unsigned SB_STOP = 2;
  localparam int unsigned SB_TMO  = 7;
  localparam int unsigned SB_OCR  = 12;
  localparam int unsigned SB_ERR  = 14;

  localparam logic [STAT_W-1:0] KEEP_OCR_READY = 16'hE000;
  localparam logic [STAT_W-1:0] KEEP_ERR_CLEAN = 16'hB000;

endpackage

// File: rtl/cmdr_decode.sv
module cmdr_decode
  import cmdr_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_fields_t      fields
);

  always_comb begin
    fields.idx   = word[5:0];
    fields.init  = word[7];
    fields.ctype = word[13:12];
    fields.dir   = word[15];
    unique case (word[10:8])
      3'd0:    fields.kind = RK_NONE;
      3'd1:    fields.kind = word[11] ? RK_R1B : RK_R1;
      3'd2:    fields.kind = RK_R2;
      3'd3:    fields.kind = RK_R3;
      3'd6:    fields.kind = RK_R6;
      default: fields.kind = RK_RAW;
    endcase
  end

endmodule

// File: rtl/cmdr_resp_eval.sv
module cmdr_resp_eval
  import cmdr_pkg::*;
#(
  parameter int unsigned       RSP_BYTES   = 16,
  parameter int unsigned       CNT_W       = $clog2(RSP_BYTES + 1),
  parameter logic [31:0]       R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [31:0]       R6_ERR_MASK = 32'h0000_E008
) (
  input  rkind_e                 kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [RSP_BYTES*8-1:0] bytes,
  output logic [STAT_W-1:0]      and_m,
  output logic [STAT_W-1:0]      or_m,
  output logic                   store
);

  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(4);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(RSP_BYTES);

  logic [31:0]       head;
  logic [31:0]       chk_mask;
  logic [31:0]       chk_val;
  logic              tmo;
  logic [STAT_W-1:0] km;
  logic [STAT_W-1:0] sm;

  assign head = {bytes[7:0], bytes[15:8], bytes[23:16], bytes[31:24]};

  // Status effects are folded in order into one keep mask and one set mask
  always_comb begin
    tmo      = 1'b0;
    chk_mask = '0;
    chk_val  = '0;
    km       = '1;
    sm       = '0;
    store    = (cnt != '0);

    unique case (kind)
      RK_NONE: store = 1'b0;
      RK_R1, RK_R1B: begin
        if (cnt < SHORT_CNT) tmo = 1'b1;
        else begin
          chk_mask = R1_ERR_MASK;
          chk_val  = head;
        end
      end
      RK_R2: begin
        if (cnt < FULL_CNT) tmo = 1'b1;
      end
      RK_R3: begin
        if (cnt < SHORT_CNT) tmo = 1'b1;
        else if (head[31]) km = km & KEEP_OCR_READY;
        else sm[SB_OCR] = 1'b1;
      end
      RK_R6: begin
        if (cnt < SHORT_CNT) tmo = 1'b1;
        else begin
          chk_mask = R6_ERR_MASK;
          chk_val  = {16'h0000, head[15:0]};
        end
      end
      default: ;
    endcase

    if (|(chk_val & chk_mask)) begin
      sm[SB_ERR] = 1'b1;
    end else begin
      km = km & KEEP_ERR_CLEAN;
      sm = sm & KEEP_ERR_CLEAN;
    end

    if (tmo) begin
      sm[SB_TMO] = 1'b1;
    end else if (idx == IDX_STOP) begin
      sm[SB_DONE] = 1'b1;
      sm[SB_STOP] = 1'b1;
    end else begin
      sm[SB_DONE] = 1'b1;
    end

    and_m = km;
    or_m  = sm;
  end

endmodule

// File: rtl/cmdr_rsp_bank.sv
module cmdr_rsp_bank #(
  parameter int unsigned RSP_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   load,
  input  logic [RSP_BYTES*8-1:0] bytes,
  output logic [RSP_BYTES*8-1:0] regs
);

  localparam int unsigned NWORDS = RSP_BYTES / 2;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam int unsigned SLOT = NWORDS - 1 - k;
    logic [15:0] word_d;
    logic [15:0] word_q;
    logic        word_en;

    assign word_en = clr | load;

    always_comb begin
      word_d = word_q;
      if (clr)       word_d = '0;
      else if (load) word_d = {bytes[16*k +: 8], bytes[16*k+8 +: 8]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign regs[16*SLOT +: 16] = word_q;
  end

endmodule

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit
  import cmdr_pkg::*;
#(
  parameter int unsigned RSP_BYTES   = 16,
  parameter int unsigned CNT_W       = $clog2(RSP_BYTES + 1),
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [31:0] R6_ERR_MASK = 32'h0000_E008
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   cmd_wr,
  input  logic [CMD_W-1:0]       cmd_wdata,
  input  logic [ARG_W-1:0]       cmd_arg,
  output logic                   req_valid,
  output logic [IDX_W-1:0]       req_index,
  output logic [ARG_W-1:0]       req_arg,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [CNT_W-1:0]       rsp_count,
  input  logic [RSP_BYTES*8-1:0] rsp_bytes,
  output logic                   stat_upd,
  output logic [STAT_W-1:0]      stat_and,
  output logic [STAT_W-1:0]      stat_or,
  output logic [RSP_BYTES*8-1:0] rsp_regs,
  output logic                   xfer_start,
  output logic                   xfer_cancel,
  output logic                   xfer_dir
);

  typedef enum logic {ST_IDLE, ST_WAIT} phase_e;

  phase_e            phase_q, phase_d;
  cmd_fields_t       fld;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ARG_W-1:0]  arg_q, arg_d;
  rkind_e            kind_q, kind_d;
  logic              upd_q, upd_d;
  logic [STAT_W-1:0] and_q, and_d;
  logic [STAT_W-1:0] or_q, or_d;
  logic              xs_q, xs_d;
  logic              xc_q, xc_d;
  logic              dir_q, dir_d;

  logic              accept;
  logic              startup;
  logic              hs;
  logic [STAT_W-1:0] ev_and;
  logic [STAT_W-1:0] ev_or;
  logic              ev_store;
  logic              cmd_en;

  cmdr_decode u_dec (
    .word   (cmd_wdata),
    .fields (fld)
  );

  cmdr_resp_eval #(
    .RSP_BYTES   (RSP_BYTES),
    .CNT_W       (CNT_W),
    .R1_ERR_MASK (R1_ERR_MASK),
    .R6_ERR_MASK (R6_ERR_MASK)
  ) u_eval (
    .kind  (kind_q),
    .idx   (idx_q),
    .cnt   (rsp_count),
    .bytes (rsp_bytes),
    .and_m (ev_and),
    .or_m  (ev_or),
    .store (ev_store)
  );

  cmdr_rsp_bank #(
    .RSP_BYTES (RSP_BYTES)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .load  (hs & ev_store),
    .bytes (rsp_bytes),
    .regs  (rsp_regs)
  );

  assign accept  = cmd_wr & en & (phase_q == ST_IDLE);
  assign startup = fld.init & (fld.idx == '0);
  assign hs      = (phase_q == ST_WAIT) & rsp_valid;
  assign cmd_en  = accept & ~startup;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    arg_d   = arg_q;
    kind_d  = kind_q;
    dir_d   = dir_q;
    upd_d   = 1'b0;
    and_d   = '1;
    or_d    = '0;
    xs_d    = 1'b0;
    xc_d    = 1'b0;

    unique case (phase_q)
      ST_IDLE: begin
        if (accept && startup) begin
          upd_d          = 1'b1;
          or_d[SB_DONE]  = 1'b1;
        end else if (cmd_en) begin
          phase_d = ST_WAIT;
          idx_d   = fld.idx;
          arg_d   = cmd_arg;
          kind_d  = fld.kind;
          if (fld.ctype == CT_DATA) begin
            xs_d  = 1'b1;
            dir_d = fld.dir;
          end else begin
            xc_d  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          phase_d = ST_IDLE;
          upd_d   = 1'b1;
          and_d   = ev_and;
          or_d    = ev_or;
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  // request fields: loaded only when a command is launched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      arg_q  <= '0;
      kind_q <= RK_NONE;
    end else if (cmd_en) begin
      idx_q  <= idx_d;
      arg_q  <= arg_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else if (xs_d) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      upd_q   <= 1'b0;
      and_q   <= '1;
      or_q    <= '0;
      xs_q    <= 1'b0;
      xc_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      upd_q   <= upd_d;
      and_q   <= and_d;
      or_q    <= or_d;
      xs_q    <= xs_d;
      xc_q    <= xc_d;
    end
  end

  assign req_valid   = (phase_q == ST_WAIT);
  assign rsp_ready   = (phase_q == ST_WAIT);
  assign req_index   = idx_q;
  assign req_arg     = arg_q;
  assign stat_upd    = upd_q;
  assign stat_and    = and_q;
  assign stat_or     = or_q;
  assign xfer_start  = xs_q;
  assign xfer_cancel = xc_q;
  assign xfer_dir    = dir_q;

endmodule

// File: rtl/cmdr_chk.sv
module cmdr_chk
  import cmdr_pkg::*;
#(
  parameter int unsigned RSP_BYTES = 16,
  parameter int unsigned CNT_W     = $clog2(RSP_BYTES + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic                   cmd_wr,
  input logic [CMD_W-1:0]       cmd_wdata,
  input logic                   req_valid,
  input logic [IDX_W-1:0]       req_index,
  input logic [ARG_W-1:0]       req_arg,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic                   stat_upd,
  input logic [STAT_W-1:0]      stat_and,
  input logic [STAT_W-1:0]      stat_or,
  input logic [RSP_BYTES*8-1:0] rsp_regs,
  input logic                   xfer_start,
  input logic                   xfer_cancel,
  input logic                   xfer_dir
);

  logic take;
  logic boot;
  assign take = cmd_wr && en && !req_valid;
  assign boot = cmd_wdata[7] && (cmd_wdata[5:0] == 6'd0);

  a_r1_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

  a_r1_ready_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !boot) |=> (req_valid && rsp_ready && req_index == $past(cmd_wdata[5:0])));

  a_r2_disabled_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req_valid) |=> !req_valid);

  a_r3_regs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rsp_regs == '0));

  a_r4_startup_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (take && boot) |=> (stat_upd && stat_or == 16'h0001 && stat_and == 16'hFFFF
                        && !req_valid && !xfer_start && !xfer_cancel));

  a_r5_timeout_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_upd && stat_or[SB_TMO]) |-> !stat_or[SB_ERR]);

  a_r9_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |-> (stat_or[SB_DONE] != stat_or[SB_TMO]));

  a_r10_start_with_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !boot && cmd_wdata[13:12] == 2'd3) |=> (xfer_start && xfer_dir == $past(cmd_wdata[15])));

  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_start && xfer_cancel));

  a_r11_update_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> stat_upd);

endmodule

bind cmd_resp_unit cmdr_chk #(
  .RSP_BYTES (RSP_BYTES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .cmd_wr      (cmd_wr),
  .cmd_wdata   (cmd_wdata),
  .req_valid   (req_valid),
  .req_index   (req_index),
  .req_arg     (req_arg),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .stat_upd    (stat_upd),
  .stat_and    (stat_and),
  .stat_or     (stat_or),
  .rsp_regs    (rsp_regs),
  .xfer_start  (xfer_start),
  .xfer_cancel (xfer_cancel),
  .xfer_dir    (xfer_dir)
);

// File: tb/sim_cmd_resp_unit.sv
`timescale 1ns/1ps
module sim_cmd_resp_unit;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic         cmd_wr;
  logic [15:0]  cmd_wdata;
  logic [31:0]  cmd_arg;
  logic         req_valid;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid;
  logic         rsp_ready;
  logic [4:0]   rsp_count;
  logic [127:0] rsp_bytes;
  logic         stat_upd;
  logic [15:0]  stat_and;
  logic [15:0]  stat_or;
  logic [127:0] rsp_regs;
  logic         xfer_start;
  logic         xfer_cancel;
  logic         xfer_dir;

  cmd_resp_unit u0 (
    .clk (clk), .rst_n (rst_n), .en (en), .cmd_wr (cmd_wr), .cmd_wdata (cmd_wdata),
    .cmd_arg (cmd_arg), .req_valid (req_valid), .req_index (req_index), .req_arg (req_arg),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_count (rsp_count),
    .rsp_bytes (rsp_bytes), .stat_upd (stat_upd), .stat_and (stat_and), .stat_or (stat_or),
    .rsp_regs (rsp_regs), .xfer_start (xfer_start), .xfer_cancel (xfer_cancel),
    .xfer_dir (xfer_dir)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_cmp;
  int    n_bad;
  int    cyc;
  bit    finished;
  string tag;
  logic  reseed;

  // behavioural reference state
  bit          m_wait;
  int          m_idx;
  logic [31:0] m_arg;
  int          m_code;
  bit          m_upd;
  bit          m_xs;
  bit          m_xc;
  bit          m_dir;
  logic [15:0] m_rsp [8];
  logic [15:0] m_stat;
  logic [15:0] b_stat;

  function automatic logic [7:0] rbyte(int i);
    return rsp_bytes[8*i +: 8];
  endfunction

  task automatic model_response();
    logic [31:0] w;
    logic [31:0] msk;
    logic [31:0] val;
    bit          tmo;
    bit          keep;
    int          cnt;
    cnt  = int'(rsp_count);
    w    = {rbyte(0), rbyte(1), rbyte(2), rbyte(3)};
    msk  = 0;
    val  = 0;
    tmo  = 0;
    keep = (cnt != 0);
    case (m_code)
      0: keep = 0;
      1: if (cnt < 4) tmo = 1; else begin msk = 32'hFDF90000; val = w; end
      2: if (cnt < 16) tmo = 1;
      3: if (cnt < 4) tmo = 1;
         else if (w[31]) m_stat = m_stat & 16'hE000;
         else m_stat = m_stat | 16'h1000;
      6: if (cnt < 4) tmo = 1; else begin msk = 32'h0000E008; val = w & 32'h0000FFFF; end
      default: ;
    endcase
    if ((val & msk) != 0) m_stat = m_stat | 16'h4000;
    else m_stat = m_stat & 16'hB000;
    if (keep)
      for (int k = 0; k < 8; k++) m_rsp[7-k] = {rbyte(2*k), rbyte(2*k+1)};
    if (tmo) m_stat = m_stat | 16'h0080;
    else if (m_idx == 12) m_stat = m_stat | 16'h0005;
    else m_stat = m_stat | 16'h0001;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_wait = 0; m_idx = 0; m_arg = 0; m_code = 0;
      m_upd = 0; m_xs = 0; m_xc = 0; m_dir = 0;
      for (int k = 0; k < 8; k++) m_rsp[k] = 16'h0;
      m_stat = 16'hFFFF;
    end else begin
      m_upd = 0; m_xs = 0; m_xc = 0;
      if (reseed) m_stat = 16'hFFFF;
      if (m_wait) begin
        if (rsp_valid) begin
          model_response();
          m_wait = 0;
          m_upd  = 1;
        end
      end else if (cmd_wr && en) begin
        for (int k = 0; k < 8; k++) m_rsp[k] = 16'h0;
        if (cmd_wdata[7] && cmd_wdata[5:0] == 0) begin
          m_stat = m_stat | 16'h0001;
          m_upd  = 1;
        end else begin
          m_wait = 1;
          m_idx  = int'(cmd_wdata[5:0]);
          m_arg  = cmd_arg;
          m_code = int'(cmd_wdata[10:8]);
          if (cmd_wdata[13:12] == 2'd3) begin m_xs = 1; m_dir = cmd_wdata[15]; end
          else m_xc = 1;
        end
      end
    end
  end

  task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    n_cmp = n_cmp + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reseed) b_stat = 16'hFFFF;
      if (stat_upd) b_stat = (b_stat & stat_and) | stat_or;
      check(req_valid == m_wait, "req_valid", 128'(req_valid), 128'(m_wait));
      check(rsp_ready == m_wait, "rsp_ready", 128'(rsp_ready), 128'(m_wait));
      if (m_wait) begin
        check(int'(req_index) == m_idx, "req_index", 128'(req_index), 128'(m_idx));
        check(req_arg == m_arg, "req_arg", 128'(req_arg), 128'(m_arg));
      end
      check(stat_upd == m_upd, "stat_upd", 128'(stat_upd), 128'(m_upd));
      if (!reseed) check(b_stat == m_stat, "status", 128'(b_stat), 128'(m_stat));
      for (int k = 0; k < 8; k++)
        check(rsp_regs[16*k +: 16] == m_rsp[k], "rsp_reg", 128'(rsp_regs[16*k +: 16]), 128'(m_rsp[k]));
      check(xfer_start == m_xs, "xfer_start", 128'(xfer_start), 128'(m_xs));
      check(xfer_cancel == m_xc, "xfer_cancel", 128'(xfer_cancel), 128'(m_xc));
      if (m_xs) check(xfer_dir == m_dir, "xfer_dir", 128'(xfer_dir), 128'(m_dir));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic seed(string t);
    tick();
    tag    = t;
    reseed = 1'b1;
    tick();
    reseed = 1'b0;
  endtask

  task automatic write_cmd(logic [15:0] w, logic [31:0] a);
    cmd_wr    = 1'b1;
    cmd_wdata = w;
    cmd_arg   = a;
    tick();
    cmd_wr    = 1'b0;
  endtask

  task automatic respond(int cnt, logic [127:0] b, int dly);
    while (!req_valid) tick();
    repeat (dly) tick();
    rsp_valid = 1'b1;
    rsp_count = 5'(cnt);
    rsp_bytes = b;
    tick();
    rsp_valid = 1'b0;
    rsp_bytes = {16{8'hEE}};
    tick();
  endtask

  function automatic logic [127:0] ramp(logic [7:0] base);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = base + 8'(i * 17);
    return r;
  endfunction

  function automatic logic [127:0] head4(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    logic [127:0] r;
    r = ramp(8'h10);
    r[31:0] = {b3, b2, b1, b0};
    return r;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; finished = 0;
    tag = "R1"; reseed = 1'b0; b_stat = 16'hFFFF;
    rst_n = 1'b0; en = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; cmd_arg = '0;
    rsp_valid = 1'b0; rsp_count = '0; rsp_bytes = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state: all outputs idle (R3 registers zero)
    check(rsp_regs == '0 && !req_valid && !stat_upd, "R3 reset", rsp_regs, 128'h0);

    // R2: writes with enable low do nothing
    seed("R2");
    write_cmd(16'h0111, 32'h1111_2222);
    repeat (3) tick();
    en = 1'b1;
    tick();

    // R1 + R9 + R8: short-status command, clean response
    seed("R1");
    write_cmd(16'h0111, 32'hCAFE_0001);
    // R2: second write while waiting is ignored
    tag = "R2";
    write_cmd(16'h0080, 32'h0);
    tag = "R8";
    respond(6, head4(8'h00, 8'h00, 8'h09, 8'h00), 2);

    // R4: start-up shortcut
    seed("R4");
    write_cmd(16'h0080, 32'h0);
    repeat (2) tick();

    // R3: next command clears stored words
    seed("R3");
    write_cmd(16'h0111, 32'h0000_0005);
    tick();
    tag = "R7";
    respond(4, head4(8'h80, 8'h00, 8'h00, 8'h00), 0);

    // R5: short count for short-status and long kinds
    seed("R5");
    write_cmd(16'h0111, 32'h7);
    respond(2, ramp(8'h31), 1);
    seed("R5");
    write_cmd(16'h0202, 32'h8);
    respond(15, ramp(8'h42), 0);
    seed("R8");
    write_cmd(16'h0202, 32'h9);
    respond(16, ramp(8'h53), 3);

    // R6: operating-conditions kind, both polarities
    seed("R6");
    write_cmd(16'h0329, 32'h00FF_8000);
    respond(4, head4(8'h80, 8'hFF, 8'h80, 8'h00), 0);
    seed("R6");
    write_cmd(16'h0329, 32'h00FF_8000);
    respond(4, head4(8'h00, 8'hFF, 8'h80, 8'h00), 0);

    // R7: address kind error bits
    seed("R7");
    write_cmd(16'h0603, 32'h0);
    respond(4, head4(8'hAB, 8'hCD, 8'h20, 8'h00), 0);
    seed("R7");
    write_cmd(16'h0603, 32'h0);
    respond(4, head4(8'hAB, 8'hCD, 8'h00, 8'h08), 1);
    seed("R7");
    write_cmd(16'h0603, 32'h0);
    respond(4, head4(8'hAB, 8'hCD, 8'h00, 8'h10), 0);

    // R9: stop command with busy hint
    seed("R9");
    write_cmd(16'h090C, 32'h0);
    respond(4, head4(8'h00, 8'h00, 8'h0B, 8'h00), 0);

    // R10: data-class commands with both directions, then a non-data class
    seed("R10");
    write_cmd(16'hB112, 32'h0000_0200);
    respond(4, head4(8'h00, 8'h00, 8'h09, 8'h00), 0);
    seed("R10");
    write_cmd(16'h3119, 32'h0000_0400);
    respond(4, head4(8'h00, 8'h00, 8'h09, 8'h00), 0);
    seed("R10");
    write_cmd(16'h2107, 32'h1);
    respond(4, head4(8'h00, 8'h00, 8'h09, 8'h00), 0);

    // R8: no-response kind keeps nothing; unlisted kind keeps bytes
    seed("R8");
    write_cmd(16'h0000, 32'h0);
    respond(16, ramp(8'h64), 0);
    seed("R8");
    write_cmd(16'h0507, 32'h0);
    respond(4, ramp(8'h75), 0);

    // R11: long response delay
    seed("R11");
    write_cmd(16'h0111, 32'h5);
    respond(4, head4(8'h00, 8'h00, 8'h09, 8'h00), 7);
    repeat (3) tick();
    summary();
  end

endmodule